// File: doc/BRIEF.md
# Text Cursor Overlay with Blink

This block places a text cursor onto character-mode pixel data just before that data goes to the dot serializer. Each clock it receives one pattern byte, the refresh address that fetched it, and the raster line within the character row. The block inverts the visible dots of the byte when the cursor applies. The cursor applies when the refresh address equals the programmed 16-bit cursor address and the raster line falls inside the programmed start/end window.

The cursor can be off, steady, or blinking. Blinking is timed in display frames by counting frame pulses. The half-period is selectable between 16 and 32 frames. In graphics mode the cursor never appears and bytes pass through unchanged. The modified byte is registered, so it leaves the block one clock after its input.

Top module: `cursor_overlay`

## Requirements
- R1: While `rstN` is low, `pixelOut` is 0x00 and the blink phase returns to visible. The blink phase also starts from visible when `rstN` is released.
- R2: `pixelOut` is registered. The byte presented with its inputs at clock edge k appears on `pixelOut` after edge k. When no cursor applies, it equals `pixelIn` unchanged.
- R3: `cursorMode` sets the cursor behaviour: 2'b00 and 2'b01 turn it off, 2'b10 gives a steady cursor, and 2'b11 gives a blinking cursor.
- R4: The cursor applies only when all 16 bits of `refreshAddr` equal `cursorAddr`.
- R5: `cursorTop` and `cursorBottom` hold the first and last cursor line minus one. The cursor applies on raster line r (counted from 0) only when cursorTop <= r <= cursorBottom, with both ends inclusive.
- R6: `vertPitch` holds the character height minus one. If `cursorTop` or `cursorBottom` exceeds `vertPitch`, the cursor is never applied.
- R7: `charPitch` holds the dot pitch minus one. The cursor covers `pixelIn` bits 7 down to 7-charPitch; for example, a field value of 3 covers 0xF0 and 7 covers 0xFF.
- R8: The cursor is merged by exclusive-OR: `pixelOut` = `pixelIn` ^ mask, so dots that are already lit under the cursor go dark.
- R9: When `graphicsMode` is 1, the cursor never applies.
- R10: In blink mode, the phase toggles once every 16 `framePulse` cycles when `blinkFast`=1 and once every 32 when `blinkFast`=0. The cursor shows only while the phase is visible. Steady mode ignores the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| framePulse | input | 1 | One-cycle strobe, once per display frame |
| refreshAddr | input | 16 | Address the current pattern byte was fetched from |
| rasterLine | input | 4 | Raster line within the character row, from 0 |
| pixelIn | input | 8 | Pattern byte, leftmost dot in bit 7 |
| cursorAddr | input | 16 | Cursor position address |
| cursorMode | input | 2 | Cursor off / steady / blink |
| blinkFast | input | 1 | 1: 16-frame half-period, 0: 32-frame |
| cursorTop | input | 4 | First cursor line minus one |
| cursorBottom | input | 4 | Last cursor line minus one |
| vertPitch | input | 4 | Character height minus one |
| charPitch | input | 3 | Dot pitch minus one |
| graphicsMode | input | 1 | 1 selects graphics mode |
| pixelOut | output | 8 | Byte with the cursor merged in |

## Verification
The hidden half of the blink cycle is the hardest state to reach, because it exists only after a precise count of frame pulses and cannot be loaded directly. The stimulus issues exactly 15 pulses and confirms the cursor is still shown, then issues the 16th and confirms it is gone. It then switches to the 32-frame period and repeats the count on the other side of the toggle. Reset is also asserted while the phase is hidden, to show that it returns to visible.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic rowInWindow;    // raster line is inside a legal cursor window
    logic cursorEnable;   // mode, blink phase and graphics allow a cursor
  } cursorStrobeT;
endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
#(
  parameter int RASTER_W    = 4,
  parameter int SLOW_FRAMES = 32,
  parameter int FAST_FRAMES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                framePulse,
  input  logic [RASTER_W-1:0] rasterLine,
  input  logic [1:0]          cursorMode,
  input  logic                blinkFast,
  input  logic [RASTER_W-1:0] cursorTop,
  input  logic [RASTER_W-1:0] cursorBottom,
  input  logic [RASTER_W-1:0] vertPitch,
  input  logic                graphicsMode,
  output cursorStrobeT        strobes
);
  localparam int CNT_W = $clog2(SLOW_FRAMES);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_FRAMES - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_FRAMES - 1);

  logic [CNT_W-1:0] frameCount;
  logic             blinkVisible;
  logic [CNT_W-1:0] lastCount;

  assign lastCount = blinkFast ? FAST_LAST : SLOW_LAST;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameCount   <= '0;
      blinkVisible <= 1'b1;
    end else if (framePulse) begin
      if (frameCount >= lastCount) begin
        frameCount   <= '0;
        blinkVisible <= ~blinkVisible;
      end else begin
        frameCount <= frameCount + 1'b1;
      end
    end
  end

  logic windowLegal;
  assign windowLegal = (cursorTop <= vertPitch) && (cursorBottom <= vertPitch);

  always_comb begin
    strobes.rowInWindow  = windowLegal && (cursorTop <= rasterLine) && (rasterLine <= cursorBottom);
    strobes.cursorEnable = !graphicsMode && cursorMode[1] && (!cursorMode[0] || blinkVisible);
  end
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int PITCH_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  cursorStrobeT       strobes,
  input  logic [ADDR_W-1:0]  refreshAddr,
  input  logic [ADDR_W-1:0]  cursorAddr,
  input  logic [PITCH_W-1:0] charPitch,
  input  logic [DATA_W-1:0]  pixelIn,
  output logic [DATA_W-1:0]  pixelOut
);
  logic [DATA_W-1:0] widthMask;
  logic              addrHit;
  logic              applyCursor;

  // Leftmost charPitch+1 dots, counting down from the MSB
  for (genvar g = 0; g < DATA_W; g++) begin : gMask
    assign widthMask[g] = (int'(charPitch) + g) >= (DATA_W - 1);
  end

  assign addrHit     = (refreshAddr == cursorAddr);
  assign applyCursor = addrHit && strobes.rowInWindow && strobes.cursorEnable;

  always_ff @(posedge clk) begin
    if (!rstN) pixelOut <= '0;
    else       pixelOut <= pixelIn ^ (applyCursor ? widthMask : '0);
  end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int RASTER_W    = 4,
  parameter int PITCH_W     = 3,
  parameter int SLOW_FRAMES = 32,
  parameter int FAST_FRAMES = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                framePulse,
  input  logic [ADDR_W-1:0]   refreshAddr,
  input  logic [RASTER_W-1:0] rasterLine,
  input  logic [DATA_W-1:0]   pixelIn,
  input  logic [ADDR_W-1:0]   cursorAddr,
  input  logic [1:0]          cursorMode,
  input  logic                blinkFast,
  input  logic [RASTER_W-1:0] cursorTop,
  input  logic [RASTER_W-1:0] cursorBottom,
  input  logic [RASTER_W-1:0] vertPitch,
  input  logic [PITCH_W-1:0]  charPitch,
  input  logic                graphicsMode,
  output logic [DATA_W-1:0]   pixelOut
);
  cursorStrobeT strobes;

  cursor_ctrl #(
    .RASTER_W(RASTER_W), .SLOW_FRAMES(SLOW_FRAMES), .FAST_FRAMES(FAST_FRAMES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .rasterLine(rasterLine),
    .cursorMode(cursorMode), .blinkFast(blinkFast), .cursorTop(cursorTop),
    .cursorBottom(cursorBottom), .vertPitch(vertPitch),
    .graphicsMode(graphicsMode), .strobes(strobes)
  );

  cursor_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PITCH_W(PITCH_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .refreshAddr(refreshAddr),
    .cursorAddr(cursorAddr), .charPitch(charPitch), .pixelIn(pixelIn),
    .pixelOut(pixelOut)
  );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int RASTER_W = 4,
  parameter int PITCH_W  = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                graphicsMode,
  input logic [1:0]          cursorMode,
  input logic [ADDR_W-1:0]   refreshAddr,
  input logic [ADDR_W-1:0]   cursorAddr,
  input logic [RASTER_W-1:0] cursorTop,
  input logic [RASTER_W-1:0] vertPitch,
  input logic [PITCH_W-1:0]  charPitch,
  input logic [DATA_W-1:0]   pixelIn,
  input logic [DATA_W-1:0]   pixelOut
);
  AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    !cursorMode[1] |=> pixelOut == $past(pixelIn)); // R3

  AST_ADDR_MISS_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (refreshAddr != cursorAddr) |=> pixelOut == $past(pixelIn)); // R4

  AST_BAD_WINDOW_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    (cursorTop > vertPitch) |=> pixelOut == $past(pixelIn)); // R6

  AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(pixelOut ^ $past(pixelIn)) == 0) ||
             ($countones(pixelOut ^ $past(pixelIn)) == int'($past(charPitch)) + 1)); // R7

  AST_GRAPHICS_PASSES: assert property (@(posedge clk) disable iff (!rstN)
    graphicsMode |=> pixelOut == $past(pixelIn)); // R9

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> pixelOut == '0); // R1
endmodule

bind cursor_overlay cursor_overlay_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RASTER_W(RASTER_W), .PITCH_W(PITCH_W)
) chk (.*);

// File: tb/cursor_overlay_test.sv
`timescale 1ns/1ps
module cursor_overlay_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        framePulse = 1'b0;
  logic [15:0] refreshAddr = '0;
  logic [3:0]  rasterLine = '0;
  logic [7:0]  pixelIn = '0;
  logic [15:0] cursorAddr = 16'h0123;
  logic [1:0]  cursorMode = 2'b10;
  logic        blinkFast = 1'b1;
  logic [3:0]  cursorTop = 4'd2;
  logic [3:0]  cursorBottom = 4'd6;
  logic [3:0]  vertPitch = 4'd7;
  logic [2:0]  charPitch = 3'd7;
  logic        graphicsMode = 1'b0;
  logic [7:0]  pixelOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cursor_overlay uut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .refreshAddr(refreshAddr),
    .rasterLine(rasterLine), .pixelIn(pixelIn), .cursorAddr(cursorAddr),
    .cursorMode(cursorMode), .blinkFast(blinkFast), .cursorTop(cursorTop),
    .cursorBottom(cursorBottom), .vertPitch(vertPitch), .charPitch(charPitch),
    .graphicsMode(graphicsMode), .pixelOut(pixelOut)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       hit;
    logic [3:0] raster;
    logic [3:0] top;
    logic [3:0] bot;
    logic [3:0] vp;
    logic [2:0] pitch;
    logic       gfx;
    logic [7:0] pix;
    logic [7:0] exp;
  } vecT;

  localparam int NVEC = 16;
  localparam vecT VEC [NVEC] = '{
    '{2'b10, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'hC3}, // R3 steady, R8 xor
    '{2'b00, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'h3C}, // R3 off
    '{2'b01, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'h3C}, // R3 off
    '{2'b11, 1'b1, 4'd3, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'hC3}, // R3 blink visible
    '{2'b10, 1'b0, 4'd2, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'h3C}, // R4 miss
    '{2'b10, 1'b1, 4'd1, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'h3C}, // R5 above
    '{2'b10, 1'b1, 4'd6, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'hC3}, // R5 last line
    '{2'b10, 1'b1, 4'd7, 4'd2, 4'd6, 4'd7, 3'd7, 1'b0, 8'h3C, 8'h3C}, // R5 below
    '{2'b10, 1'b1, 4'd3, 4'd0, 4'd15, 4'd7, 3'd7, 1'b0, 8'h3C, 8'h3C}, // R6 bottom>vp
    '{2'b10, 1'b1, 4'd8, 4'd8, 4'd8, 4'd7, 3'd7, 1'b0, 8'h3C, 8'h3C}, // R6 top>vp
    '{2'b10, 1'b1, 4'd7, 4'd7, 4'd7, 4'd7, 3'd7, 1'b0, 8'h3C, 8'hC3}, // R6 edge legal
    '{2'b10, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd3, 1'b0, 8'h00, 8'hF0}, // R7 pitch 4
    '{2'b10, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd4, 1'b0, 8'h0F, 8'hF7}, // R7 pitch 5
    '{2'b10, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd5, 1'b0, 8'hFF, 8'h03}, // R7 R8 pitch 6
    '{2'b10, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd7, 1'b1, 8'h3C, 8'h3C}, // R9 graphics
    '{2'b11, 1'b1, 4'd2, 4'd2, 4'd6, 4'd7, 3'd7, 1'b1, 8'h5A, 8'h5A}  // R9 graphics blink
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pixelOut=%02h expected %02h", req, act, exp);
    end
  endtask

  // Apply a byte at a negedge, sample one cycle later
  task automatic apply(input logic [7:0] pix);
    pixelIn = pix;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      framePulse = 1'b1;
      @(negedge clk);
      framePulse = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    refreshAddr = cursorAddr;
    pixelIn = 8'hA5;
    repeat (3) @(negedge clk);
    check("R1 reset output", pixelOut, 8'h00);
    rstN = 1'b1;

    // R2 latency and passthrough
    cursorMode = 2'b00;
    apply(8'h96);
    check("R2 passthrough", pixelOut, 8'h96);

    for (int v = 0; v < NVEC; v++) begin
      cursorMode   = VEC[v].mode;
      refreshAddr  = VEC[v].hit ? cursorAddr : (cursorAddr ^ 16'h8000);
      rasterLine   = VEC[v].raster;
      cursorTop    = VEC[v].top;
      cursorBottom = VEC[v].bot;
      vertPitch    = VEC[v].vp;
      charPitch    = VEC[v].pitch;
      graphicsMode = VEC[v].gfx;
      apply(VEC[v].pix);
      check($sformatf("table row %0d", v), pixelOut, VEC[v].exp);
    end

    // Directed: R4 single low-bit address miss
    cursorMode = 2'b10; graphicsMode = 1'b0; charPitch = 3'd7;
    cursorTop = 4'd2; cursorBottom = 4'd6; vertPitch = 4'd7; rasterLine = 4'd4;
    refreshAddr = cursorAddr ^ 16'h0001;
    apply(8'h00);
    check("R4 low bit miss", pixelOut, 8'h00);
    refreshAddr = cursorAddr;

    // R10 blink, fast period
    cursorMode = 2'b11; blinkFast = 1'b1;
    pulses(15);
    apply(8'h00);
    check("R10 still visible after 15 frames", pixelOut, 8'hFF);
    pulses(1);
    apply(8'h00);
    check("R10 hidden after 16 frames", pixelOut, 8'h00);
    cursorMode = 2'b10;
    apply(8'h00);
    check("R10 steady ignores phase", pixelOut, 8'hFF);
    cursorMode = 2'b11;

    // R10 slow period from hidden phase
    blinkFast = 1'b0;
    pulses(31);
    apply(8'h00);
    check("R10 hidden after 31 slow frames", pixelOut, 8'h00);
    pulses(1);
    apply(8'h00);
    check("R10 visible after 32 slow frames", pixelOut, 8'hFF);

    // R1 reset restores visible phase
    blinkFast = 1'b1;
    pulses(16);
    apply(8'h00);
    check("R10 hidden again", pixelOut, 8'h00);
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", pixelOut, 8'h00);
    rstN = 1'b1;
    apply(8'h00);
    check("R1 phase visible after reset", pixelOut, 8'hFF);

    finish_run();
  end
endmodule